// File: doc/BRIEF.md
# Locked Watchdog Timer with Reset Budget

This block supervises a processor by counting timebase ticks down from a value chosen by software. When the count runs out before software restarts it, the block drives a fixed-length reset pulse toward the system reset logic. Software talks to it through a small write port: one register turns the watchdog on, one holds the reload value used for later restarts, and one takes the two-word key that restarts the countdown.

Protection against runaway software comes from three rules. A restart needs two consecutive key writes in a fixed order. The on bit cannot be cleared by software. The first countdown after the watchdog is turned on is longer than later ones, which gives boot code time to finish. A counter kept in the power-on reset domain records how many resets the watchdog has caused. Once a set budget is used up, a further expiry raises a give-up flag and produces no pulse, so broken hardware cannot cause an endless reset loop.

The integrator ANDs the reset output into the system reset. `rst_n` therefore falls while the pulse is high, and it clears the enable, the countdown, the key state and the staged reload value. The fired-count, the last-cause bit and the give-up flag are cleared only by `por_n`.

Top module: `wdog_guard`

## Requirements
- R1: After either reset the watchdog is off, the status reads 3'b000 after a power-on reset, and while it stays off no reset pulse is ever produced, however many ticks arrive.
- R2: A write to address 0 with data bit 0 set turns the watchdog on (status bit 0). Later writes to address 0, including ones with bit 0 clear, neither turn it off nor restart its count. Only `rst_n` or `por_n` clears it.
- R3: When the watchdog is turned on, the countdown is loaded with INIT_LOAD. With no restart, `wd_rst_o` is first high in the clock cycle after the INIT_LOAD-th tick edge that counts.
- R4: A write of KEY0 (default 16'h5555) to address 2, followed directly by a write of KEY1 (default 16'hAAAA) to address 2, restarts the countdown from the staged reload value. The next expiry then comes that many ticks after the edge of the second write.
- R5: A key sequence is dropped without a restart if the word after KEY0 is any value other than KEY1 (KEY0 again included), if the words come in the other order, or if a write to another address falls between the two key words.
- R6: A write to address 1 only stages a new reload value. The running countdown keeps its current value, and the staged value is loaded at the next successful key sequence. After `rst_n` the staged value is DEF_RELOAD.
- R7: The countdown advances only on clock edges where `tick_i` is high. Edges with `tick_i` low add the same number of cycles to the time until expiry.
- R8: On expiry, `wd_rst_o` is high for exactly PULSE_LEN (default 16) consecutive clock cycles, starting at the clock edge on which the expiring tick is sampled.
- R9: Status bit 1 is set by each watchdog reset pulse, stays set through the `rst_n` that the pulse causes, and is cleared only by `por_n`.
- R10: The block produces at most RST_LIMIT reset pulses between power-on resets. The expiry that comes after that budget is used up produces no pulse and sets status bit 2 (give-up), which only `por_n` clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears every register |
| rst_n | input | 1 | Asynchronous active-low system reset; clears the enable, countdown, key state and staged reload |
| tick_i | input | 1 | Timebase tick; one countdown step per clock edge on which it is high |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 reload, 2 key |
| wr_data_i | input | DW | Write data |
| wd_rst_o | output | 1 | Registered reset pulse, PULSE_LEN cycles long |
| status_o | output | 3 | {give-up, last reset by watchdog, enabled} |

## Verification
Every register write is sampled on one clock edge and acts on that same edge. A key completion or an enable therefore sets the countdown at the edge that samples the final write, and the status reflects it at the following falling edge. The reset pulse turns on at the edge that samples the expiring tick: with a countdown of N loaded at edge L and a tick every cycle, `wd_rst_o` is first high after edge L+N and last high after edge L+N+PULSE_LEN-1. Because the pulse pulls `rst_n` low at once, the enable bit reads 0 from that same cycle. The driver records the edge index of every write. It places each expected value in the scoreboard at exactly that offset, and pairs a check one cycle before each deadline with a check on the deadline itself. The monitor compares outputs only at falling edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [AW-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [AW-1:0] ADDR_KEY    = 2'd2;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  typedef struct packed {
    logic give_up;
    logic last_wd;
    logic enabled;
  } wd_status_t;

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter logic [DW-1:0] KEY0 = 16'h5555,
  parameter logic [DW-1:0] KEY1 = 16'hAAAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          kick_o
);

  key_state_e state_q, state_d;

  // Two-word unlock: KEY0 arms, KEY1 right after completes.
  // Anything else, on any address, drops back to idle.
  always_comb begin
    state_d = state_q;
    kick_o  = 1'b0;
    if (wr_en_i) begin
      if (wr_addr_i == ADDR_KEY) begin
        case (state_q)
          KS_IDLE:  state_d = (wr_data_i == KEY0) ? KS_ARMED : KS_IDLE;
          KS_ARMED: begin
            kick_o  = (wr_data_i == KEY1);
            state_d = KS_IDLE;
          end
          default:  state_d = KS_IDLE;
        endcase
      end else begin
        state_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  // A completed sequence must have been armed in the previous cycle
  AST_KICK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> (state_q == KS_ARMED)); // R4

  // A foreign write never leaves the sequencer armed
  AST_FOREIGN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i != ADDR_KEY) |=> (state_q == KS_IDLE)); // R5

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned INIT_LOAD  = 40000,
  parameter int unsigned DEF_RELOAD = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          kick_i,
  output logic          enabled_o,
  output logic          expire_o
);

  localparam logic [DW-1:0] INIT_VAL   = DW'(INIT_LOAD);
  localparam logic [DW-1:0] RELOAD_RST = DW'(DEF_RELOAD);
  localparam logic [DW-1:0] ONE        = DW'(1);

  logic          en_q, en_d;
  logic          done_q, done_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] stage_q, stage_d;
  logic          en_set;
  logic          stage_wr;

  assign en_set   = wr_en_i && (wr_addr_i == ADDR_CTRL) && wr_data_i[0] && !en_q;
  assign stage_wr = wr_en_i && (wr_addr_i == ADDR_RELOAD);

  always_comb begin
    en_d     = en_q | en_set;
    stage_d  = stage_wr ? wr_data_i : stage_q;
    cnt_d    = cnt_q;
    done_d   = done_q;
    expire_o = 1'b0;
    if (en_set) begin
      cnt_d  = INIT_VAL;
      done_d = 1'b0;
    end else if (en_q && kick_i) begin
      cnt_d  = stage_q;
      done_d = 1'b0;
    end else if (en_q && tick_i && !done_q) begin
      if (cnt_q <= ONE) begin
        cnt_d    = '0;
        done_d   = 1'b1;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      stage_q <= RELOAD_RST;
    end else begin
      en_q    <= en_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end

  assign enabled_o = en_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R2

  AST_NO_SPONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_i && !en_set) |=> (cnt_q <= $past(cnt_q))); // R6

  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tick_i && !kick_i) |=> $stable(cnt_q)); // R7

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !expire_o); // R1

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int unsigned RST_LIMIT = 4,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic expire_i,
  output logic wd_rst_o,
  output logic last_wd_o,
  output logic give_up_o
);

  localparam int unsigned CW = $clog2(RST_LIMIT + 1);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(RST_LIMIT);
  localparam logic [PW-1:0] PULSE_V = PW'(PULSE_LEN);

  logic [CW-1:0] fired_q, fired_d;
  logic [PW-1:0] rem_q, rem_d;
  logic          pulse_q, pulse_d;
  logic          last_q, last_d;
  logic          quit_q, quit_d;
  logic          at_limit;
  logic          fire;

  assign at_limit = (fired_q == LIMIT_V);
  assign fire     = expire_i && !at_limit;

  always_comb begin
    fired_d = fired_q;
    rem_d   = rem_q;
    if (fire) begin
      rem_d   = PULSE_V;
      fired_d = fired_q + CW'(1);
    end else if (rem_q != '0) begin
      rem_d = rem_q - PW'(1);
    end
    pulse_d = (rem_d != '0);
    last_d  = last_q | fire;
    quit_d  = quit_q | (expire_i && at_limit);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fired_q <= '0;
      rem_q   <= '0;
      pulse_q <= 1'b0;
      last_q  <= 1'b0;
      quit_q  <= 1'b0;
    end else begin
      fired_q <= fired_d;
      rem_q   <= rem_d;
      pulse_q <= pulse_d;
      last_q  <= last_d;
      quit_q  <= quit_d;
    end
  end

  assign wd_rst_o  = pulse_q;
  assign last_wd_o = last_q;
  assign give_up_o = quit_q;

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pulse_q) |-> $past(expire_i)); // R8

  AST_LAST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    last_q |=> last_q); // R9

  AST_GIVEUP_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    quit_q |=> quit_q); // R10

  AST_NO_PULSE_GAVEUP: assert property (@(posedge clk) disable iff (!por_n)
    quit_q |-> !$rose(pulse_q)); // R10

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned INIT_LOAD  = 40000,
  parameter int unsigned DEF_RELOAD = 10000,
  parameter int unsigned RST_LIMIT  = 4,
  parameter int unsigned PULSE_LEN  = 16,
  parameter logic [DW-1:0] KEY0     = 16'h5555,
  parameter logic [DW-1:0] KEY1     = 16'hAAAA
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wd_rst_o,
  output logic [2:0]    status_o
);

  logic       sys_rst_n;
  logic       kick;
  logic       enabled;
  logic       expire;
  wd_status_t stat;

  // The system-domain logic also falls with the power-on reset
  assign sys_rst_n = rst_n & por_n;

  wdog_keyseq #(
    .DW   (DW),
    .KEY0 (KEY0),
    .KEY1 (KEY1)
  ) u_keyseq (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .kick_o    (kick)
  );

  wdog_countdown #(
    .DW         (DW),
    .INIT_LOAD  (INIT_LOAD),
    .DEF_RELOAD (DEF_RELOAD)
  ) u_countdown (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .kick_i    (kick),
    .enabled_o (enabled),
    .expire_o  (expire)
  );

  wdog_rstgen #(
    .RST_LIMIT (RST_LIMIT),
    .PULSE_LEN (PULSE_LEN)
  ) u_rstgen (
    .clk       (clk),
    .por_n     (por_n),
    .expire_i  (expire),
    .wd_rst_o  (wd_rst_o),
    .last_wd_o (stat.last_wd),
    .give_up_o (stat.give_up)
  );

  assign stat.enabled = enabled;
  assign status_o     = stat;

endmodule

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;

  localparam int unsigned DW = 16;

  typedef struct {
    int unsigned cyc;
    string       tag;
    logic        exp_rst;
    logic [2:0]  exp_st;
  } item_t;

  logic          clk = 1'b0;
  logic          por_n;
  logic          rst_n;
  logic          tick;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic          wd_rst;
  logic [2:0]    status;

  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;
  item_t       sb_q[$];

  always #10 clk = ~clk;

  // System reset: power-on reset combined with the watchdog pulse
  assign rst_n = por_n & ~wd_rst;

  wdog_guard #(
    .DW         (DW),
    .INIT_LOAD  (40),
    .DEF_RELOAD (10),
    .RST_LIMIT  (2),
    .PULSE_LEN  (16)
  ) u_dut (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .wd_rst_o  (wd_rst),
    .status_o  (status)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every expected item due in this cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.cyc != cyc) begin
        errors++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.cyc, cyc);
      end else if (wd_rst !== it.exp_rst || status !== it.exp_st) begin
        errors++;
        $display("FAIL %s at cycle %0d: wd_rst=%b status=%b, expected wd_rst=%b status=%b",
                 it.tag, cyc, wd_rst, status, it.exp_rst, it.exp_st);
      end
    end
  end

  // Driver side: push an expected item, kept sorted by cycle
  task automatic expect_at(input int unsigned c, input string tag,
                           input logic r, input logic [2:0] s);
    item_t it;
    int    pos;
    it.cyc = c; it.tag = tag; it.exp_rst = r; it.exp_st = s;
    pos = sb_q.size();
    for (int i = 0; i < sb_q.size(); i++) begin
      if (sb_q[i].cyc > c) begin
        pos = i;
        break;
      end
    end
    sb_q.insert(pos, it);
  endtask

  // Called at a falling edge; the write acts on the next rising edge,
  // whose index equals cyc when the task returns.
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd3; wr_data = '0;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (cycle %0d)", cyc);
      finish_run();
    end
  end

  initial begin
    int unsigned e, k, k2;
    por_n = 1'b0; tick = 1'b1;
    wr_en = 1'b0; wr_addr = 2'd3; wr_data = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1: reset state, and no pulse while off with ticks running
    expect_at(cyc + 1,  "R1", 1'b0, 3'b000);
    expect_at(cyc + 60, "R1", 1'b0, 3'b000);
    drain();

    // R2/R3/R8/R9: enable, try to disable, expire on the first timeout
    wr(2'd0, 16'h0001);
    e = cyc;
    expect_at(e + 1, "R2", 1'b0, 3'b001);
    repeat (8) @(negedge clk);
    wr(2'd0, 16'h0000);
    expect_at(cyc + 1, "R2", 1'b0, 3'b001);
    expect_at(e + 39, "R3", 1'b0, 3'b001);
    expect_at(e + 40, "R8", 1'b1, 3'b010);
    expect_at(e + 55, "R8", 1'b1, 3'b010);
    expect_at(e + 56, "R9", 1'b0, 3'b010);
    drain();

    // R4/R5/R6: kick loads the staged value; staged writes and broken
    // sequences afterwards leave the running countdown alone
    wr(2'd1, 16'd30);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'hAAAA);
    k = cyc;
    wr(2'd1, 16'd50);
    wr(2'd2, 16'h5555);
    wr(2'd1, 16'd7);      // foreign write between key words
    wr(2'd2, 16'hAAAA);
    wr(2'd2, 16'hAAAA);   // wrong order
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'h1234);   // wrong second word
    wr(2'd2, 16'hAAAA);
    expect_at(k + 29, "R6", 1'b0, 3'b011);
    expect_at(k + 30, "R5", 1'b1, 3'b010);
    expect_at(k + 46, "R8", 1'b0, 3'b010);
    drain();

    // R4/R5/R10: good kicks keep it alive; budget of 2 is spent, so the
    // next expiry gives up instead of pulsing
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd50);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'hAAAA);
    k = cyc;
    while (cyc < k + 38) @(negedge clk);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'hAAAA);
    k2 = cyc;
    expect_at(k + 51, "R4", 1'b0, 3'b011);
    while (cyc < k2 + 42) @(negedge clk);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'h5555);   // repeated first word
    wr(2'd2, 16'hAAAA);
    expect_at(k2 + 49, "R4", 1'b0, 3'b011);
    expect_at(k2 + 50, "R10", 1'b0, 3'b111);
    expect_at(k2 + 70, "R10", 1'b0, 3'b111);
    drain();

    // R9/R10: power-on reset clears the persistent flags and budget
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    expect_at(cyc + 1, "R10", 1'b0, 3'b000);
    drain();

    // R7: 20 edges without tick delay expiry by 20 cycles
    wr(2'd0, 16'h0001);
    e = cyc;
    tick = 1'b0;
    repeat (20) @(negedge clk);
    tick = 1'b1;
    expect_at(e + 40, "R7", 1'b0, 3'b001);
    expect_at(e + 59, "R7", 1'b0, 3'b001);
    expect_at(e + 60, "R7", 1'b1, 3'b010);
    drain();

    repeat (20) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end

endmodule